// File: doc/BRIEF.md
# Real-Time Calendar Timekeeping Core

This core holds a wall-clock time and date in eight byte-wide fields: seconds, minutes, hours, day of week, day of month, month, two-digit year and century. A prescaler counts strobes from a 32.768 kHz time base. Once per second it advances the whole calendar in a single clock cycle, carrying through minutes, hours, days, months, years and centuries. Each field can be coded as packed BCD digits or as plain binary. Hours can be kept in 24-hour form or in 12-hour form with a PM flag.

A host reads and writes the fields and two control bytes through a simple index/data port. Near the end of each second the core raises an update-in-progress status, so software knows to wait before it reads a consistent time. In the cycle where the fields advance, the core emits a one-cycle update-ended pulse for a neighbouring interrupt block.

A freeze bit stops the advance while software loads a new time. The divider-control field can hold the prescaler in reset. When that hold is released, the first update comes half a second later.

Top module: `rtc_calendar`

## Requirements
- R1: `uip_o` is 1 during exactly the last UIP_TICKS prescaler strobes of each second, including the strobe that updates the calendar. It reads as bit 7 of control A (index 8), and a host write to that bit has no effect.
- R2: While bit 7 of control B (index 9, freeze) is 1, the time fields do not advance, `update_o` stays 0 and `uip_o` reads 0. A write of control B with bit 7 set stores bit 4 (update-interrupt enable) as 0.
- R3: The calendar advances only when the freeze bit is 0 and control A bits 6:4 are 2 or less. When bits 6:5 are both 1, the prescaler is held at zero, and there is no update and no `uip_o`.
- R4: When control A is written from a held setting (bits 6:5 = 11) to a setting with bits 6:4 at most 2, the first update comes after half a second of strobes (2^(DIV_W-1)) instead of a full second.
- R5: With control B bit 2 at 0 (BCD), every field holds tens in bits 7:4 and units in bits 3:0. Seconds and minutes roll 59 to 00 and carry into the next field; 24-hour time rolls 23 to 00.
- R6: With control B bit 2 at 1, the fields hold plain binary values and roll over at the same limits.
- R7: With control B bit 1 at 0 (12-hour), hours are stored as 1 to 12, with bit 7 set for PM. The sequence 11 PM goes to 12 AM (the next day), 11 AM goes to 12 PM, and 12 goes to 1.
- R8: Day of week runs 1 to 7 and wraps to 1. Day of month rolls over at the month's length (30 for months 4, 6, 9 and 11; 28 for month 2, or 29 when the year is divisible by 4; 31 otherwise). Month 12 wraps to 1. Year 99 wraps to 00 and increments the century.
- R9: `update_o` is a one-cycle pulse in the same cycle that the fields take their advanced values. No field changes in any other cycle, except through a host write.
- R10: Index map: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 century, 8 control A, 9 control B, 10 status D. After reset: control A 0x26, control B 0x02 (24-hour, BCD), status D 0x80, time 00:00:00, date fields 0x01, year 0x00, century 0x20. Status D ignores writes.
- R11: When a host write to a time field lands in an update cycle, that field takes the written value. The other fields advance from their values before the update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_32k | input | 1 | One-cycle strobe at the 32.768 kHz time-base rate |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Index of the written register |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 4 | Index of the read register |
| rd_data | output | 8 | Read data for `rd_addr` (combinational) |
| uip_o | output | 1 | Update-in-progress status |
| update_o | output | 1 | Update-ended pulse, one cycle |

## Verification
A host write and a calendar update can fall in the same clock cycle. The bench provokes this by waiting until `update_o` is high and driving a seconds write in that very cycle, with the time set to 05:10:59. It then expects 05:11:30: the write wins for the seconds field, and the minute carry comes from the old seconds value. The half-second release and the UIP window are judged by counting strobes between events, not by reading any internal counter.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] IX_SEC  = 4'd0;
  localparam logic [ADDR_W-1:0] IX_MIN  = 4'd1;
  localparam logic [ADDR_W-1:0] IX_HOUR = 4'd2;
  localparam logic [ADDR_W-1:0] IX_DOW  = 4'd3;
  localparam logic [ADDR_W-1:0] IX_DOM  = 4'd4;
  localparam logic [ADDR_W-1:0] IX_MON  = 4'd5;
  localparam logic [ADDR_W-1:0] IX_YEAR = 4'd6;
  localparam logic [ADDR_W-1:0] IX_CENT = 4'd7;
  localparam logic [ADDR_W-1:0] IX_CTLA = 4'd8;
  localparam logic [ADDR_W-1:0] IX_CTLB = 4'd9;
  localparam logic [ADDR_W-1:0] IX_STSD = 4'd10;

  localparam logic [7:0] CTLA_RST = 8'h26;
  localparam logic [7:0] CTLB_RST = 8'h02;
  localparam logic [7:0] STSD_VAL = 8'h80;

  typedef struct packed {
    logic [7:0] cent;
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] dom;
    logic [7:0] dow;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  // Decode a stored field to its numeric value (binary or packed BCD).
  function automatic logic [6:0] field_to_bin(input logic [7:0] v, input logic bin_mode);
    logic [6:0] t;
    t = 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    return bin_mode ? v[6:0] : t;
  endfunction

  // Encode a numeric value back into the selected field coding.
  function automatic logic [7:0] bin_to_field(input logic [6:0] n, input logic bin_mode);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = n / 7'd10;
    ones = n % 7'd10;
    return bin_mode ? {1'b0, n} : {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [6:0] days_in_month(input logic [6:0] mon, input logic [6:0] yr);
    case (mon)
      7'd2:                    return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
      default:                 return 7'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W     = 15,
  parameter int UIP_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic count_en,
  input  logic hold,
  input  logic load_half,
  output logic uip_win,
  output logic roll
);

  localparam logic [DIV_W-1:0] PH_MAX   = {DIV_W{1'b1}};
  localparam logic [DIV_W-1:0] PH_HALF  = {1'b1, {(DIV_W-1){1'b0}}};
  localparam logic [DIV_W-1:0] PH_UIP   = PH_MAX - DIV_W'(UIP_TICKS - 1);

  logic [DIV_W-1:0] phase_q, phase_d;
  logic             phase_en;

  always_comb begin
    phase_en = load_half | hold | (tick & count_en);
    if (load_half)   phase_d = PH_HALF;
    else if (hold)   phase_d = '0;
    else             phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (phase_en) phase_q <= phase_d;
  end

  assign roll    = tick & count_en & ~hold & ~load_half & (phase_q == PH_MAX);
  assign uip_win = (phase_q >= PH_UIP);

  // R1: every roll of the second falls inside the UIP window
  assert_roll_in_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    roll |-> uip_win);

  // R9: the update strobe never lasts two cycles
  assert_roll_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> !roll);

endmodule

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
  import rtc_cal_pkg::*;
(
  input  rtc_time_t cur,
  input  logic      bin_mode,
  input  logic      h24,
  output rtc_time_t nxt
);

  logic [6:0] s, m, h, raw_h, dw, dm, mo, y, c, dim;
  logic [6:0] s_n, m_n, h_n, h12, dw_n, dm_n, mo_n, y_n, c_n;
  logic       c_min, c_hr, c_day, c_mon, c_yr, c_cen;

  always_comb begin
    s     = field_to_bin(cur.sec, bin_mode);
    m     = field_to_bin(cur.min, bin_mode);
    raw_h = field_to_bin({1'b0, cur.hour[6:0]}, bin_mode);
    h     = h24 ? raw_h : ((raw_h % 7'd12) + (cur.hour[7] ? 7'd12 : 7'd0));
    dw    = field_to_bin(cur.dow, bin_mode);
    dm    = field_to_bin(cur.dom, bin_mode);
    mo    = field_to_bin(cur.mon, bin_mode);
    y     = field_to_bin(cur.year, bin_mode);
    c     = field_to_bin(cur.cent, bin_mode);
    dim   = days_in_month(mo, y);

    c_min = (s >= 7'd59);
    s_n   = c_min ? 7'd0 : s + 7'd1;
    c_hr  = c_min & (m >= 7'd59);
    m_n   = (m >= 7'd59) ? 7'd0 : m + 7'd1;
    c_day = c_hr & (h >= 7'd23);
    h_n   = (h >= 7'd23) ? 7'd0 : h + 7'd1;
    dw_n  = (dw >= 7'd7) ? 7'd1 : dw + 7'd1;
    c_mon = c_day & (dm >= dim);
    dm_n  = (dm >= dim) ? 7'd1 : dm + 7'd1;
    c_yr  = c_mon & (mo >= 7'd12);
    mo_n  = (mo >= 7'd12) ? 7'd1 : mo + 7'd1;
    c_cen = c_yr & (y >= 7'd99);
    y_n   = (y >= 7'd99) ? 7'd0 : y + 7'd1;
    c_n   = (c >= 7'd99) ? 7'd0 : c + 7'd1;
    h12   = ((h_n % 7'd12) == 7'd0) ? 7'd12 : (h_n % 7'd12);

    nxt      = cur;
    nxt.sec  = bin_to_field(s_n, bin_mode);
    if (c_min) nxt.min = bin_to_field(m_n, bin_mode);
    if (c_hr) begin
      if (h24) nxt.hour = bin_to_field(h_n, bin_mode);
      else     nxt.hour = bin_to_field(h12, bin_mode) | ((h_n >= 7'd12) ? 8'h80 : 8'h00);
    end
    if (c_day) begin
      nxt.dow = bin_to_field(dw_n, bin_mode);
      nxt.dom = bin_to_field(dm_n, bin_mode);
    end
    if (c_mon) nxt.mon  = bin_to_field(mo_n, bin_mode);
    if (c_yr)  nxt.year = bin_to_field(y_n, bin_mode);
    if (c_cen) nxt.cent = bin_to_field(c_n, bin_mode);
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int DIV_W     = 15,
  parameter int UIP_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              uip_o,
  output logic              update_o
);

  localparam rtc_time_t TIME_RST = '{cent: 8'h20, year: 8'h00, mon: 8'h01, dom: 8'h01,
                                      dow: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};

  // reset synchronizer: assert asynchronously, release on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  rtc_time_t  time_q, time_d, time_step;
  logic [6:0] ctla_q, ctla_d;
  logic [7:0] ctlb_q, ctlb_d;
  logic       time_en, ctla_en, ctlb_en;
  logic       wr_time, wr_a, wr_b;
  logic       div_hold, div_count, frozen, running;
  logic       load_half, uip_win, roll;

  assign div_hold  = (ctla_q[6:5] == 2'b11);
  assign div_count = (ctla_q[6:4] <= 3'd2);
  assign frozen    = ctlb_q[7];
  assign running   = div_count & ~frozen;

  assign wr_time   = wr_en & (wr_addr <= IX_CENT);
  assign wr_a      = wr_en & (wr_addr == IX_CTLA);
  assign wr_b      = wr_en & (wr_addr == IX_CTLB);
  assign load_half = wr_a & div_hold & (wr_data[6:4] <= 3'd2);

  rtc_prescaler #(.DIV_W(DIV_W), .UIP_TICKS(UIP_TICKS)) u_presc (
    .clk       (clk),
    .rst_n     (rst_ni),
    .tick      (tick_32k),
    .count_en  (div_count),
    .hold      (div_hold),
    .load_half (load_half),
    .uip_win   (uip_win),
    .roll      (roll)
  );

  rtc_cal_step u_step (
    .cur      (time_q),
    .bin_mode (ctlb_q[2]),
    .h24      (ctlb_q[1]),
    .nxt      (time_step)
  );

  assign update_o = roll & ~frozen;
  assign uip_o    = uip_win & running;

  // next state: update first, host write to a field overrides it
  always_comb begin
    time_en = update_o | wr_time;
    time_d  = update_o ? time_step : time_q;
    if (wr_time) begin
      case (wr_addr)
        IX_SEC:  time_d.sec  = wr_data;
        IX_MIN:  time_d.min  = wr_data;
        IX_HOUR: time_d.hour = wr_data;
        IX_DOW:  time_d.dow  = wr_data;
        IX_DOM:  time_d.dom  = wr_data;
        IX_MON:  time_d.mon  = wr_data;
        IX_YEAR: time_d.year = wr_data;
        default: time_d.cent = wr_data;
      endcase
    end
    ctla_en = wr_a;
    ctla_d  = wr_data[6:0];
    ctlb_en = wr_b;
    ctlb_d  = wr_data[7] ? (wr_data & 8'hEF) : wr_data;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= TIME_RST;
      ctla_q <= CTLA_RST[6:0];
      ctlb_q <= CTLB_RST;
    end else begin
      if (time_en) time_q <= time_d;
      if (ctla_en) ctla_q <= ctla_d;
      if (ctlb_en) ctlb_q <= ctlb_d;
    end
  end

  always_comb begin
    case (rd_addr)
      IX_SEC:  rd_data = time_q.sec;
      IX_MIN:  rd_data = time_q.min;
      IX_HOUR: rd_data = time_q.hour;
      IX_DOW:  rd_data = time_q.dow;
      IX_DOM:  rd_data = time_q.dom;
      IX_MON:  rd_data = time_q.mon;
      IX_YEAR: rd_data = time_q.year;
      IX_CENT: rd_data = time_q.cent;
      IX_CTLA: rd_data = {uip_o, ctla_q};
      IX_CTLB: rd_data = ctlb_q;
      IX_STSD: rd_data = STSD_VAL;
      default: rd_data = 8'h00;
    endcase
  end

  // R2: a freezing write leaves the update-interrupt enable cleared
  assert_set_clears_uie_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_b && wr_data[7]) |=> !ctlb_q[4]);

  // R3: a held divider produces neither an update nor a UIP status
  assert_hold_quiet_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    div_hold |-> (!update_o && !uip_o));

  // R9: seconds move only on an update pulse or a host write
  assert_sec_hold_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (!update_o && !(wr_en && wr_addr == IX_SEC)) |=> $stable(time_q.sec));

  // R1: the update pulse is seen with UIP still high
  assert_update_in_uip_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    update_o |-> uip_o);

endmodule

// File: tb/tb_rtc_calendar.sv
module tb_rtc_calendar;
  import rtc_cal_pkg::*;

  localparam int DIV_W = 6;
  localparam int UIP_TICKS = 8;
  localparam int HALF = 1 << (DIV_W - 1);
  localparam int FULL = 1 << DIV_W;

  logic       clk, rst_n, tick_32k, wr_en;
  logic [3:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       uip_o, update_o;

  int n_chk, n_bad;
  bit done;

  rtc_calendar #(.DIV_W(DIV_W), .UIP_TICKS(UIP_TICKS)) dut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .uip_o(uip_o), .update_o(update_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_upd();
    do @(negedge clk); while (!update_o);
  endtask

  task automatic after_upd();
    wait_upd();
    @(negedge clk);
  endtask

  task automatic load(input logic [7:0] b_run, input logic [7:0] hr, input logic [7:0] mi,
                      input logic [7:0] se, input logic [7:0] dw, input logic [7:0] dm,
                      input logic [7:0] mo, input logic [7:0] yr, input logic [7:0] ce);
    wr(IX_CTLB, b_run | 8'h80);
    wr(IX_SEC, se); wr(IX_MIN, mi); wr(IX_HOUR, hr); wr(IX_DOW, dw);
    wr(IX_DOM, dm); wr(IX_MON, mo); wr(IX_YEAR, yr); wr(IX_CENT, ce);
    wr(IX_CTLB, b_run);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(IX_CTLA, v); chk("R10 ctl A", v, 8'h26);
    rd(IX_CTLB, v); chk("R10 ctl B", v, 8'h02);
    rd(IX_STSD, v); chk("R10 status D", v, 8'h80);
    rd(IX_SEC, v);  chk("R10 seconds", v, 8'h00);
    rd(IX_DOM, v);  chk("R10 day", v, 8'h01);
    rd(IX_CENT, v); chk("R10 century", v, 8'h20);
    wr(IX_STSD, 8'h00);
    rd(IX_STSD, v); chk("R10 status D write ignored", v, 8'h80);
  endtask

  task automatic t_bcd_rollover();
    logic [7:0] v;
    load(8'h02, 8'h23, 8'h59, 8'h59, 8'h07, 8'h28, 8'h02, 8'h23, 8'h20);
    after_upd();
    rd(IX_SEC, v);  chk("R5 sec", v, 8'h00);
    rd(IX_MIN, v);  chk("R5 min", v, 8'h00);
    rd(IX_HOUR, v); chk("R5 hour", v, 8'h00);
    rd(IX_DOW, v);  chk("R8 dow wrap", v, 8'h01);
    rd(IX_DOM, v);  chk("R8 feb non-leap dom", v, 8'h01);
    rd(IX_MON, v);  chk("R8 feb non-leap mon", v, 8'h03);
  endtask

  task automatic t_leap_and_year();
    logic [7:0] v;
    load(8'h02, 8'h23, 8'h59, 8'h59, 8'h02, 8'h28, 8'h02, 8'h24, 8'h20);
    after_upd();
    rd(IX_DOM, v); chk("R8 leap dom", v, 8'h29);
    rd(IX_MON, v); chk("R8 leap mon", v, 8'h02);
    load(8'h02, 8'h23, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h99, 8'h20);
    after_upd();
    rd(IX_DOM, v);  chk("R8 new year dom", v, 8'h01);
    rd(IX_MON, v);  chk("R8 new year mon", v, 8'h01);
    rd(IX_YEAR, v); chk("R8 year wrap", v, 8'h00);
    rd(IX_CENT, v); chk("R8 century", v, 8'h21);
  endtask

  task automatic t_twelve_hour();
    logic [7:0] v;
    load(8'h00, 8'h91, 8'h59, 8'h59, 8'h03, 8'h15, 8'h06, 8'h10, 8'h20);
    after_upd();
    rd(IX_HOUR, v); chk("R7 11PM->12AM", v, 8'h12);
    rd(IX_DOM, v);  chk("R7 day after midnight", v, 8'h16);
    load(8'h00, 8'h11, 8'h59, 8'h59, 8'h03, 8'h15, 8'h06, 8'h10, 8'h20);
    after_upd();
    rd(IX_HOUR, v); chk("R7 11AM->12PM", v, 8'h92);
    load(8'h00, 8'h92, 8'h59, 8'h59, 8'h03, 8'h15, 8'h06, 8'h10, 8'h20);
    after_upd();
    rd(IX_HOUR, v); chk("R7 12PM->1PM", v, 8'h81);
  endtask

  task automatic t_binary();
    logic [7:0] v;
    load(8'h06, 8'd23, 8'd59, 8'd59, 8'd7, 8'd30, 8'd4, 8'd5, 8'd20);
    after_upd();
    rd(IX_SEC, v);  chk("R6 sec", v, 8'd0);
    rd(IX_HOUR, v); chk("R6 hour", v, 8'd0);
    rd(IX_DOM, v);  chk("R6 30-day month dom", v, 8'd1);
    rd(IX_MON, v);  chk("R6 month", v, 8'd5);
    load(8'h06, 8'd10, 8'd20, 8'd9, 8'd1, 8'd1, 8'd1, 8'd0, 8'd20);
    after_upd();
    rd(IX_SEC, v);  chk("R6 9->10 binary", v, 8'd10);
  endtask

  task automatic t_freeze();
    logic [7:0] v;
    int ups, uips;
    wr(IX_CTLB, 8'h92);
    rd(IX_CTLB, v); chk("R2 uie forced 0", v, 8'h82);
    wr(IX_SEC, 8'h10);
    ups = 0; uips = 0;
    for (int i = 0; i < 2 * FULL + 10; i++) begin
      @(negedge clk);
      if (update_o) ups++;
      if (uip_o) uips++;
    end
    chk("R2 no update while frozen", ups, 0);
    chk("R2 no uip while frozen", uips, 0);
    rd(IX_SEC, v); chk("R2 sec frozen", v, 8'h10);
    wr(IX_CTLB, 8'h02);
  endtask

  task automatic t_uip();
    logic [7:0] v;
    int cnt;
    after_upd();
    wr(IX_CTLA, 8'hA6);
    rd(IX_CTLA, v); chk("R1 uip not writable", v, 8'h26);
    wait_upd();
    cnt = 0;
    rd_addr = IX_CTLA;
    do begin
      @(negedge clk);
      if (uip_o) cnt++;
    end while (!update_o);
    #1;
    chk("R1 uip in ctl A at update", int'(rd_data[7]), 1);
    chk("R1 uip window length", cnt, UIP_TICKS);
    chk("R9 pulse width", int'(update_o), 1);
    @(negedge clk);
    chk("R9 pulse ends", int'(update_o), 0);
  endtask

  task automatic t_div_hold();
    logic [7:0] v, s0;
    int ups, uips, k;
    wr(IX_CTLA, 8'h66);
    rd(IX_SEC, s0);
    ups = 0; uips = 0;
    for (int i = 0; i < 2 * FULL; i++) begin
      @(negedge clk);
      if (update_o) ups++;
      if (uip_o) uips++;
    end
    chk("R3 no update in hold", ups, 0);
    chk("R3 no uip in hold", uips, 0);
    rd(IX_SEC, v); chk("R3 sec held", v, s0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = IX_CTLA; wr_data = 8'h26;
    k = 0;
    do begin
      @(negedge clk);
      wr_en = 1'b0;
      k++;
    end while (!update_o && k < 4 * FULL);
    chk("R4 half-second first update", k, HALF);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    load(8'h02, 8'h05, 8'h10, 8'h58, 8'h01, 8'h01, 8'h01, 8'h00, 8'h20);
    after_upd();
    wait_upd();
    wr_en = 1'b1; wr_addr = IX_SEC; wr_data = 8'h30;
    @(negedge clk);
    wr_en = 1'b0;
    rd(IX_SEC, v);  chk("R11 written field wins", v, 8'h30);
    rd(IX_MIN, v);  chk("R11 other field advances", v, 8'h11);
    rd(IX_HOUR, v); chk("R11 hour unchanged", v, 8'h05);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; tick_32k = 1'b1; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_bcd_rollover();
    t_leap_and_year();
    t_twelve_hour();
    t_binary();
    t_freeze();
    t_uip();
    t_div_hold();
    t_collision();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule